// File: doc/BRIEF.md
# Register Window Spill/Fill Controller

This block holds a group of eight windowed registers and keeps earlier groups in a memory stack. When a procedure is called, the controller copies the eight active registers to memory, one word per cycle. It then gives the program a fresh, zeroed group. When the procedure returns, it reads the most recent group back from memory, one word per cycle, and overwrites the active registers with it. Groups are saved and restored last-in first-out, so nested calls unwind in the correct order.

The core uses the register port to read and write the active window. The controller owns the memory port and the stack pointer. While a save or a restore is in progress, `busy` is high. During that time the register port and any new call or return requests are not honoured. A return that finds no saved group raises an underflow flag and does not touch memory.

Top module: `rwin_ctrl`

## Requirements
- R1: After reset, `sp` equals the parameter `SP_INIT`, `busy` and `underflow` are 0, and every window register reads 0.
- R2: An accepted call lowers `sp` by 8 on the accepting edge. It then drives `mem_we` for exactly 8 consecutive cycles. In those cycles register k (k = 0..7) is written to address `sp + k`, in ascending order.
- R3: `busy` stays high for exactly 8 cycles during a save. When it falls, all eight window registers read 0.
- R4: An accepted return drives `mem_re` for 8 consecutive cycles at addresses `sp + 0` through `sp + 7`. Memory data is taken in the cycle after each read. `busy` is high for 9 cycles. Afterwards the registers hold the restored words and `sp` has risen by 8.
- R5: Nested calls followed by the same number of returns restore each group in reverse order of saving.
- R6: A call or return request made while `busy` is high is ignored. `sp` does not change and no extra memory cycles occur.
- R7: A return made when no group is saved sets `underflow`. It causes no `mem_re` cycle, leaves `busy` low, and changes neither `sp` nor the registers. The next accepted call clears `underflow`.
- R8: While `busy` is high, register port writes are dropped and `reg_rdata` reads 0.
- R9: If a call and a return are requested in the same idle cycle, only the call is performed.
- R10: `mem_we` and `mem_re` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| call_req | input | 1 | Procedure call request (sampled when idle) |
| ret_req | input | 1 | Procedure return request (sampled when idle) |
| reg_we | input | 1 | Window register write enable |
| reg_idx | input | 3 | Window register index |
| reg_wdata | input | DATA_W | Window register write data |
| reg_rdata | output | DATA_W | Window register read data (0 while busy) |
| mem_we | output | 1 | Stack memory write strobe |
| mem_re | output | 1 | Stack memory read strobe |
| mem_addr | output | ADDR_W | Stack memory word address |
| mem_wdata | output | DATA_W | Stack memory write data |
| mem_rdata | input | DATA_W | Stack memory read data, valid one cycle after `mem_re` |
| sp | output | ADDR_W | Stack pointer |
| busy | output | 1 | Save or restore in progress |
| underflow | output | 1 | Return attempted with no saved group |

## Verification
The assertions assume that the memory returns read data exactly one cycle after `mem_re`. They also assume that the number of nested calls stays below the depth counter's range, so the saved-group count never wraps. The bench's memory model answers with that one-cycle latency. It nests calls at most two deep, and every call it issues is later matched by a return. Requests are driven between clock edges as single-cycle pulses, and the bench waits for `busy` to fall before it counts cycles or reads registers.

// File: rtl/rwin_pkg.sv
package rwin_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPILL = 2'd1,
    ST_FILL  = 2'd2,
    ST_DRAIN = 2'd3
  } rwin_state_e;
endpackage

// File: rtl/rwin_file.sv
module rwin_file #(
  parameter int DATA_W   = 32,
  parameter int WIN_REGS = 8,
  parameter int IDX_W    = $clog2(WIN_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  input  logic [IDX_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_data
);
  logic [DATA_W-1:0] win_q [WIN_REGS];

  for (genvar i = 0; i < WIN_REGS; i++) begin : g_ent
    logic              ent_en;
    logic [DATA_W-1:0] ent_d;
    logic              ld_hit;
    logic              wr_hit;

    always_comb begin
      ld_hit = ld_en && (ld_idx == IDX_W'(i));
      wr_hit = wr_en && (wr_idx == IDX_W'(i));
      ent_en = ld_hit || clr || wr_hit;
      if (ld_hit)      ent_d = ld_data;
      else if (clr)    ent_d = '0;
      else             ent_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      win_q[i] <= '0;
      else if (ent_en) win_q[i] <= ent_d;
    end
  end

  assign rd_data  = win_q[rd_idx];
  assign out_data = win_q[out_idx];

  // R8: the port write (gated by busy upstream) never meets a restore or clear
  a_r8_no_port_collide: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && (ld_en || clr)));
endmodule

// File: rtl/rwin_seq.sv
module rwin_seq
  import rwin_pkg::*;
#(
  parameter int              WIN_REGS = 8,
  parameter int              IDX_W    = $clog2(WIN_REGS),
  parameter int              ADDR_W   = 10,
  parameter int              DEPTH_W  = 6,
  parameter logic [ADDR_W-1:0] SP_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic              ret_req,
  output logic              busy_o,
  output logic [ADDR_W-1:0] sp_o,
  output logic              uflow_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [IDX_W-1:0]  cnt_o,
  output logic              clr_o,
  output logic              ld_en_o,
  output logic [IDX_W-1:0]  ld_idx_o
);
  localparam logic [ADDR_W-1:0] STEP    = ADDR_W'(WIN_REGS);
  localparam logic [IDX_W-1:0]  LAST    = IDX_W'(WIN_REGS - 1);

  rwin_state_e        state_q, state_d;
  logic [IDX_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-1:0]  sp_q, sp_d;
  logic               sp_en;
  logic [DEPTH_W-1:0] depth_q, depth_d;
  logic               depth_en;
  logic               uflow_q, uflow_d;
  logic               ld_vld_q;
  logic [IDX_W-1:0]   ld_idx_q;

  logic idle, take_call, take_ret, ret_empty, last;

  always_comb begin
    idle      = (state_q == ST_IDLE);
    take_call = idle && call_req;
    take_ret  = idle && !call_req && ret_req && (depth_q != '0);
    ret_empty = idle && !call_req && ret_req && (depth_q == '0);
    last      = (cnt_q == LAST);

    state_d  = state_q;
    cnt_d    = '0;
    sp_d     = sp_q;
    sp_en    = 1'b0;
    depth_d  = depth_q;
    depth_en = 1'b0;
    uflow_d  = uflow_q;

    unique case (state_q)
      ST_IDLE: begin
        if (take_call) begin
          state_d  = ST_SPILL;
          sp_d     = sp_q - STEP;
          sp_en    = 1'b1;
          uflow_d  = 1'b0;
        end else if (take_ret) begin
          state_d  = ST_FILL;
        end else if (ret_empty) begin
          uflow_d  = 1'b1;
        end
      end
      ST_SPILL: begin
        cnt_d = cnt_q + 1'b1;
        if (last) begin
          state_d  = ST_IDLE;
          cnt_d    = '0;
          depth_d  = depth_q + 1'b1;
          depth_en = 1'b1;
        end
      end
      ST_FILL: begin
        cnt_d = cnt_q + 1'b1;
        if (last) begin
          state_d = ST_DRAIN;
          cnt_d   = '0;
        end
      end
      ST_DRAIN: begin
        state_d  = ST_IDLE;
        sp_d     = sp_q + STEP;
        sp_en    = 1'b1;
        depth_d  = depth_q - 1'b1;
        depth_en = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sp_q     <= SP_INIT;
      depth_q  <= '0;
      uflow_q  <= 1'b0;
      ld_vld_q <= 1'b0;
      ld_idx_q <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      uflow_q  <= uflow_d;
      ld_vld_q <= (state_q == ST_FILL);
      ld_idx_q <= cnt_q;
      if (sp_en)    sp_q    <= sp_d;
      if (depth_en) depth_q <= depth_d;
    end
  end

  assign busy_o     = !idle;
  assign sp_o       = sp_q;
  assign uflow_o    = uflow_q;
  assign mem_we_o   = (state_q == ST_SPILL);
  assign mem_re_o   = (state_q == ST_FILL);
  assign mem_addr_o = sp_q + ADDR_W'(cnt_q);
  assign cnt_o      = cnt_q;
  assign clr_o      = (state_q == ST_SPILL) && last;
  assign ld_en_o    = ld_vld_q;
  assign ld_idx_o   = ld_idx_q;

  // R10: memory strobes exclusive
  a_r10_mem_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));
  // R2: every save write lands inside the eight words above sp
  a_r2_write_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> ((mem_addr_o - sp_o) < STEP));
  // R4: every restore read lands inside the eight words above sp
  a_r4_read_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re_o |-> ((mem_addr_o - sp_o) < STEP));
  // R6: sp holds while busy except on the final restore edge
  a_r6_sp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && state_q != ST_DRAIN) |=> (sp_o == $past(sp_o)));
  // R3: busy drops right after the last save write
  a_r3_spill_end: assert property (@(posedge clk) disable iff (!rst_n)
    clr_o |=> !busy_o);
  // R7: an empty return stays quiet and flags underflow
  a_r7_empty_return: assert property (@(posedge clk) disable iff (!rst_n)
    ret_empty |=> (uflow_o && !busy_o && !mem_re_o));
endmodule

// File: rtl/rwin_ctrl.sv
module rwin_ctrl #(
  parameter int              DATA_W   = 32,
  parameter int              ADDR_W   = 10,
  parameter int              DEPTH_W  = 6,
  parameter logic [ADDR_W-1:0] SP_INIT = ADDR_W'(512)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              call_req,
  input  logic              ret_req,
  input  logic              reg_we,
  input  logic [2:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] sp,
  output logic              busy,
  output logic              underflow
);
  localparam int WIN_REGS = 8;
  localparam int IDX_W    = $clog2(WIN_REGS);

  logic rst_s1_q, rst_s2_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end

  logic              clr, ld_en, port_we;
  logic [IDX_W-1:0]  cnt, ld_idx;
  logic [DATA_W-1:0] rd_data;

  rwin_seq #(
    .WIN_REGS (WIN_REGS),
    .IDX_W    (IDX_W),
    .ADDR_W   (ADDR_W),
    .DEPTH_W  (DEPTH_W),
    .SP_INIT  (SP_INIT)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_s2_q),
    .call_req   (call_req),
    .ret_req    (ret_req),
    .busy_o     (busy),
    .sp_o       (sp),
    .uflow_o    (underflow),
    .mem_we_o   (mem_we),
    .mem_re_o   (mem_re),
    .mem_addr_o (mem_addr),
    .cnt_o      (cnt),
    .clr_o      (clr),
    .ld_en_o    (ld_en),
    .ld_idx_o   (ld_idx)
  );

  assign port_we = reg_we && !busy;

  rwin_file #(
    .DATA_W   (DATA_W),
    .WIN_REGS (WIN_REGS),
    .IDX_W    (IDX_W)
  ) u_file (
    .clk      (clk),
    .rst_n    (rst_s2_q),
    .wr_en    (port_we),
    .wr_idx   (reg_idx),
    .wr_data  (reg_wdata),
    .clr      (clr),
    .ld_en    (ld_en),
    .ld_idx   (ld_idx),
    .ld_data  (mem_rdata),
    .rd_idx   (reg_idx),
    .rd_data  (rd_data),
    .out_idx  (cnt),
    .out_data (mem_wdata)
  );

  assign reg_rdata = busy ? '0 : rd_data;

  // R8: no partially restored value is visible on the read port
  a_r8_read_masked: assert property (@(posedge clk) disable iff (!rst_s2_q)
    busy |-> (reg_rdata == '0));
endmodule

// File: tb/sim_rwin_ctrl.sv
module sim_rwin_ctrl;
  localparam int DW = 32;
  localparam int AW = 10;
  localparam logic [AW-1:0] SP0 = AW'(512);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          call_req = 1'b0, ret_req = 1'b0, reg_we = 1'b0;
  logic [2:0]    reg_idx = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata, mem_wdata;
  logic [DW-1:0] mem_rdata = '0;
  logic          mem_we, mem_re, busy, underflow;
  logic [AW-1:0] mem_addr, sp;

  logic [DW-1:0] mem [0:1023];
  int checks = 0, errors = 0, wr_cnt = 0, rd_cnt = 0;

  always #2 clk = ~clk;

  rwin_ctrl #(.DATA_W(DW), .ADDR_W(AW), .SP_INIT(SP0)) u0 (
    .clk(clk), .rst_n(rst_n), .call_req(call_req), .ret_req(ret_req),
    .reg_we(reg_we), .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .sp(sp), .busy(busy), .underflow(underflow));

  always @(posedge clk) begin
    if (mem_we) begin mem[mem_addr] <= mem_wdata; wr_cnt <= wr_cnt + 1; end
    if (mem_re) begin mem_rdata <= mem[mem_addr]; rd_cnt <= rd_cnt + 1; end
  end

  task automatic chk(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int i, input logic [DW-1:0] v);
    reg_we = 1'b1; reg_idx = 3'(i); reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd_reg(input int i, output logic [DW-1:0] v);
    reg_idx = 3'(i); #1; v = reg_rdata;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 50) begin n++; @(negedge clk); end
  endtask

  task automatic pulse(input bit c, input bit r, output int n);
    call_req = c; ret_req = r;
    @(negedge clk);
    call_req = 1'b0; ret_req = 1'b0;
    wait_idle(n);
  endtask

  task automatic fill_win(input logic [DW-1:0] base);
    for (int i = 0; i < 8; i++) wr_reg(i, base + DW'(i));
  endtask

  task automatic check_win(input logic [DW-1:0] base, input bit zero, input string req);
    logic [DW-1:0] v;
    for (int i = 0; i < 8; i++) begin
      rd_reg(i, v);
      chk(v == (zero ? '0 : base + DW'(i)), req, v, zero ? '0 : base + DW'(i));
    end
  endtask

  task automatic t_reset;
    chk(sp == SP0, "R1 sp", DW'(sp), DW'(SP0));
    chk(!busy, "R1 busy", DW'(busy), 0);
    chk(!underflow, "R1 underflow", DW'(underflow), 0);
    check_win(0, 1'b1, "R1 regs zero");
  endtask

  task automatic t_call_return;
    int n, w0, r0;
    logic [AW-1:0] s0;
    logic [DW-1:0] v;
    fill_win(32'hA000_0010);
    s0 = sp; w0 = wr_cnt;
    pulse(1, 0, n);
    chk(sp == s0 - 8, "R2 sp lowered", DW'(sp), DW'(s0 - 8));
    chk(wr_cnt - w0 == 8, "R2 write cycles", DW'(wr_cnt - w0), 8);
    for (int i = 0; i < 8; i++) begin
      v = mem[sp + AW'(i)];
      chk(v == 32'hA000_0010 + DW'(i), "R2 stack order", v, 32'hA000_0010 + DW'(i));
    end
    chk(n == 8, "R3 busy length", DW'(n), 8);
    check_win(0, 1'b1, "R3 fresh window zero");
    fill_win(32'h5555_0000);
    r0 = rd_cnt;
    pulse(0, 1, n);
    chk(n == 9, "R4 busy length", DW'(n), 9);
    chk(rd_cnt - r0 == 8, "R4 read cycles", DW'(rd_cnt - r0), 8);
    chk(sp == s0, "R4 sp restored", DW'(sp), DW'(s0));
    check_win(32'hA000_0010, 1'b0, "R4 regs restored");
  endtask

  task automatic t_nested;
    int n;
    fill_win(32'h1111_0000); pulse(1, 0, n);
    fill_win(32'h2222_0000); pulse(1, 0, n);
    chk(sp == SP0 - 16, "R5 two frames", DW'(sp), DW'(SP0 - 16));
    fill_win(32'h3333_0000);
    pulse(0, 1, n);
    check_win(32'h2222_0000, 1'b0, "R5 inner frame");
    pulse(0, 1, n);
    check_win(32'h1111_0000, 1'b0, "R5 outer frame");
    chk(sp == SP0, "R5 sp home", DW'(sp), DW'(SP0));
  endtask

  task automatic t_busy_ignore;
    int n, w0, r0;
    logic [DW-1:0] v;
    fill_win(32'hBEEF_0000);
    w0 = wr_cnt; r0 = rd_cnt;
    call_req = 1'b1;
    @(negedge clk);
    call_req = 1'b1; ret_req = 1'b1;
    reg_we = 1'b1; reg_idx = 3'd2; reg_wdata = 32'hDEAD_DEAD;
    #1;
    chk(reg_rdata == '0, "R8 read masked", reg_rdata, 0);
    @(negedge clk);
    call_req = 1'b0; ret_req = 1'b0; reg_we = 1'b0;
    wait_idle(n);
    chk(sp == SP0 - 8, "R6 single frame", DW'(sp), DW'(SP0 - 8));
    chk(wr_cnt - w0 == 8, "R6 no extra writes", DW'(wr_cnt - w0), 8);
    chk(rd_cnt == r0, "R6 no reads", DW'(rd_cnt - r0), 0);
    rd_reg(2, v);
    chk(v == '0, "R8 write dropped", v, 0);
    pulse(0, 1, n);
    check_win(32'hBEEF_0000, 1'b0, "R6 frame intact");
  endtask

  task automatic t_underflow;
    int n, r0;
    fill_win(32'hC0DE_0000);
    r0 = rd_cnt;
    pulse(0, 1, n);
    chk(underflow, "R7 flag set", DW'(underflow), 1);
    chk(n == 0, "R7 no busy", DW'(n), 0);
    chk(rd_cnt == r0, "R7 no reads", DW'(rd_cnt - r0), 0);
    chk(sp == SP0, "R7 sp kept", DW'(sp), DW'(SP0));
    check_win(32'hC0DE_0000, 1'b0, "R7 regs kept");
    pulse(1, 0, n);
    chk(!underflow, "R7 cleared by call", DW'(underflow), 0);
    pulse(0, 1, n);
  endtask

  task automatic t_both;
    int n, w0, r0;
    fill_win(32'h7777_0000);
    w0 = wr_cnt; r0 = rd_cnt;
    pulse(1, 1, n);
    chk(sp == SP0 - 8, "R9 call wins sp", DW'(sp), DW'(SP0 - 8));
    chk(wr_cnt - w0 == 8, "R9 writes", DW'(wr_cnt - w0), 8);
    chk(rd_cnt == r0, "R9 no reads", DW'(rd_cnt - r0), 0);
    chk(!underflow, "R9 no underflow", DW'(underflow), 0);
    pulse(0, 1, n);
    check_win(32'h7777_0000, 1'b0, "R9 restore");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_call_return;
    t_nested;
    t_busy_ignore;
    t_underflow;
    t_both;
    // R10 is covered by the property in the sequencer; the sequences above exercise both strobes
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule